// File: doc/BRIEF.md
# FIFO Level Interrupt and Error Controller

This block sits beside a pair of FIFOs in an external-bus engine: a write (transaction) FIFO that the processor fills and a read FIFO that the engine fills. It watches both occupancy counts and raises a transmit request when the write FIFO has drained to a programmed level. It raises a receive request when the read FIFO has filled to a programmed level. It also records three error causes in sticky flags: a write attempted while the write FIFO was full, a stalled read, and a wait timeout.

The timeout is measured here. The bus engine drives `hold_off` high while an external ready or clock-enable signal is stalling a transaction. If the stall lasts longer than the programmed maximum wait, the block pulses `xfer_abort` so that the engine drops the transaction, and it latches the timeout flag. Software sees the raw status, a mask, the masked status and the error flags. Software clears the flags by writing ones. A single `irq` line combines the enabled sources.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: Status bit 0 (transmit request) is 1 one clock after `wr_count` is at or below the threshold chosen by `tx_lvl`: code 0 = 0 (empty), 1 = WDEPTH/4, 2 = WDEPTH/2, 3 = 3*WDEPTH/4. It follows the count and is not latched.
- R2: Status bit 1 (receive request) is 1 one clock after `rd_count` is at or above the threshold chosen by `rx_lvl`: code 0 = RDEPTH/8, 1 = RDEPTH/4, 2 = RDEPTH/2, 3 = 3*RDEPTH/4, 4 = 7*RDEPTH/8, and 5, 6 and 7 = RDEPTH (full). It follows the count and is not latched.
- R3: A `wfull_ev` pulse sets error flag bit 0 one clock later only when `wfull_err_en` is 1. Otherwise the pulse has no effect.
- R4: A `rstall_ev` pulse sets error flag bit 1 one clock later only when `rstall_err_en` is 1. Otherwise the pulse has no effect.
- R5: With `max_wait` = N > 0, the (N+1)th consecutive cycle with `hold_off` high is a timeout cycle. The cycle after it has `xfer_abort` = 1 for one clock and error flag bit 2 set. The wait count then restarts from zero. A low `hold_off` also restarts it.
- R6: With `max_wait` = 0, no timeout occurs however long `hold_off` stays high.
- R7: With `err_clr_we` high, each 1 in `err_clr_bits` clears the matching error flag at the next clock. Bits written as 0 leave their flags unchanged.
- R8: An enabled error event in the same cycle as a clear of its flag wins, and the flag stays set.
- R9: Status bit 2 is the OR of the three error flags.
- R10: `mask_we` loads `mask_wdata` into the mask. `masked_status` is the raw status ANDed with the mask, and `irq` is the OR of `masked_status`.
- R11: After reset, the status bits, the mask, the error flags, `xfer_abort` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_count | input | clog2(WDEPTH+1) | Write FIFO occupancy |
| rd_count | input | clog2(RDEPTH+1) | Read FIFO occupancy |
| tx_lvl | input | 2 | Transmit threshold code |
| rx_lvl | input | 3 | Receive threshold code |
| wfull_err_en | input | 1 | Enable for the write-while-full error |
| rstall_err_en | input | 1 | Enable for the read-stall error |
| max_wait | input | MW_W | Maximum stall cycles; 0 means no timeout |
| wfull_ev | input | 1 | Pulse: write attempted while write FIFO full |
| rstall_ev | input | 1 | Pulse: read stalled |
| hold_off | input | 1 | High while the transaction is held off |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 3 | New mask value |
| err_clr_we | input | 1 | Error clear strobe |
| err_clr_bits | input | 3 | Ones clear the matching error flags |
| raw_status | output | 3 | {error, receive request, transmit request} |
| masked_status | output | 3 | Raw status ANDed with the mask |
| err_flags | output | 3 | {timeout, read stall, write full} |
| xfer_abort | output | 1 | One-cycle abort after a timeout |
| irq | output | 1 | Interrupt request |

## Verification
Every registered result (both requests, all three error flags, the abort pulse and the mask) is due at the first rising edge after the input that causes it. `masked_status` and `irq` are combinational from those registers, so they are due at the same edge. The bench drives inputs on the falling edge. It updates a behavioural model at the rising edge from those same inputs, and it compares every output on the next falling edge, exactly one registered stage later. Timeout runs are counted in the model as consecutive held cycles, so the abort is expected in the cycle after the (N+1)th held cycle.

// File: rtl/fic_pkg.sv
package fic_pkg;
  localparam int ST_TX  = 0;
  localparam int ST_RX  = 1;
  localparam int ST_ERR = 2;
  localparam int ST_W   = 3;

  localparam int EF_WFULL  = 0;
  localparam int EF_RSTALL = 1;
  localparam int EF_TMO    = 2;
  localparam int EF_W      = 3;
endpackage

// File: rtl/fic_level_req.sv
module fic_level_req #(
  parameter int DEPTH = 16,
  parameter bit IS_RX = 1'b0,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [2:0]    code,
  output logic          req
);
  logic [CW-1:0] thr;
  logic          req_d;

  generate
    if (IS_RX) begin : g_rx
      always_comb begin
        case (code)
          3'd0:    thr = CW'(DEPTH / 8);
          3'd1:    thr = CW'(DEPTH / 4);
          3'd2:    thr = CW'(DEPTH / 2);
          3'd3:    thr = CW'((3 * DEPTH) / 4);
          3'd4:    thr = CW'((7 * DEPTH) / 8);
          default: thr = CW'(DEPTH);
        endcase
        req_d = (count >= thr);
      end
    end else begin : g_tx
      always_comb begin
        case (code[1:0])
          2'd0:    thr = '0;
          2'd1:    thr = CW'(DEPTH / 4);
          2'd2:    thr = CW'(DEPTH / 2);
          default: thr = CW'((3 * DEPTH) / 4);
        endcase
        req_d = (count <= thr);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else        req <= req_d;
  end

  generate
    if (IS_RX) begin : g_rx_chk
      assert_rx_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH)) |=> req);
    end else begin : g_tx_chk
      assert_tx_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |=> req);
    end
  endgenerate
endmodule

// File: rtl/fic_wait_timer.sv
module fic_wait_timer #(
  parameter int MW_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold_off,
  input  logic [MW_W-1:0] max_wait,
  output logic            tmo
);
  logic [MW_W-1:0] cnt_q, cnt_d;
  logic            timer_on;

  always_comb begin
    timer_on = (max_wait != '0);
    tmo      = hold_off && timer_on && (cnt_q == max_wait);
    if (!hold_off || !timer_on || tmo) cnt_d = '0;
    else                                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_cnt_needs_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> $past(hold_off));
  assert_off_stays_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (max_wait == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/fic_err_flags.sv
module fic_err_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic         clr_we,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] flags
);
  logic [N-1:0] clr_mask, flags_d;

  always_comb begin
    clr_mask = clr_we ? clr_bits : '0;
    flags_d  = (flags & ~clr_mask) | set_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_d;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_bits[i] && !set_ev[i]) |=> !flags[i]);
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[i] |=> flags[i]);
  end
endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl #(
  parameter int WDEPTH = 16,
  parameter int RDEPTH = 16,
  parameter int MW_W   = 8,
  localparam int WCW = $clog2(WDEPTH + 1),
  localparam int RCW = $clog2(RDEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [WCW-1:0]  wr_count,
  input  logic [RCW-1:0]  rd_count,
  input  logic [1:0]      tx_lvl,
  input  logic [2:0]      rx_lvl,
  input  logic            wfull_err_en,
  input  logic            rstall_err_en,
  input  logic [MW_W-1:0] max_wait,
  input  logic            wfull_ev,
  input  logic            rstall_ev,
  input  logic            hold_off,
  input  logic            mask_we,
  input  logic [2:0]      mask_wdata,
  input  logic            err_clr_we,
  input  logic [2:0]      err_clr_bits,
  output logic [2:0]      raw_status,
  output logic [2:0]      masked_status,
  output logic [2:0]      err_flags,
  output logic            xfer_abort,
  output logic            irq
);
  import fic_pkg::*;

  logic                tx_req, rx_req, tmo;
  logic [EF_W-1:0]     err_set;
  logic [ST_W-1:0]     mask_q, mask_d;
  logic                abort_d;

  fic_level_req #(.DEPTH(WDEPTH), .IS_RX(1'b0)) u_tx_lvl (
    .clk(clk), .rst_n(rst_n), .count(wr_count), .code({1'b0, tx_lvl}), .req(tx_req));

  fic_level_req #(.DEPTH(RDEPTH), .IS_RX(1'b1)) u_rx_lvl (
    .clk(clk), .rst_n(rst_n), .count(rd_count), .code(rx_lvl), .req(rx_req));

  fic_wait_timer #(.MW_W(MW_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .hold_off(hold_off), .max_wait(max_wait), .tmo(tmo));

  always_comb begin
    err_set            = '0;
    err_set[EF_WFULL]  = wfull_ev && wfull_err_en;
    err_set[EF_RSTALL] = rstall_ev && rstall_err_en;
    err_set[EF_TMO]    = tmo;
  end

  fic_err_flags #(.N(EF_W)) u_err (
    .clk(clk), .rst_n(rst_n), .set_ev(err_set),
    .clr_we(err_clr_we), .clr_bits(err_clr_bits), .flags(err_flags));

  always_comb begin
    mask_d  = mask_we ? mask_wdata : mask_q;
    abort_d = tmo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '0;
      xfer_abort <= 1'b0;
    end else begin
      mask_q     <= mask_d;
      xfer_abort <= abort_d;
    end
  end

  always_comb begin
    raw_status         = '0;
    raw_status[ST_TX]  = tx_req;
    raw_status[ST_RX]  = rx_req;
    raw_status[ST_ERR] = |err_flags;
    masked_status      = raw_status & mask_q;
    irq                = |masked_status;
  end

  assert_abort_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_abort |-> err_flags[EF_TMO]);
  assert_masked_off_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && mask_wdata == 3'b000) |=> !irq);
endmodule

// File: tb/fifo_irq_ctrl_tb.sv
module fifo_irq_ctrl_tb;
  localparam int WD = 16, RD = 16, MWW = 8;
  localparam int WCW = $clog2(WD + 1), RCW = $clog2(RD + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [WCW-1:0] wr_count = '0;
  logic [RCW-1:0] rd_count = '0;
  logic [1:0] tx_lvl = '0;
  logic [2:0] rx_lvl = '0;
  logic wfull_err_en = 0, rstall_err_en = 0;
  logic [MWW-1:0] max_wait = '0;
  logic wfull_ev = 0, rstall_ev = 0, hold_off = 0;
  logic mask_we = 0, err_clr_we = 0;
  logic [2:0] mask_wdata = '0, err_clr_bits = '0;
  logic [2:0] raw_status, masked_status, err_flags;
  logic xfer_abort, irq;

  int checks = 0, errors = 0;
  bit done = 0;
  string phase = "R11";

  always #2 clk = ~clk;

  fifo_irq_ctrl #(.WDEPTH(WD), .RDEPTH(RD), .MW_W(MWW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_count(wr_count), .rd_count(rd_count),
    .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .wfull_err_en(wfull_err_en),
    .rstall_err_en(rstall_err_en), .max_wait(max_wait), .wfull_ev(wfull_ev),
    .rstall_ev(rstall_ev), .hold_off(hold_off), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .err_clr_we(err_clr_we), .err_clr_bits(err_clr_bits),
    .raw_status(raw_status), .masked_status(masked_status), .err_flags(err_flags),
    .xfer_abort(xfer_abort), .irq(irq));

  // behavioural reference model
  bit m_tx, m_rx, m_abort;
  bit [2:0] m_err, m_mask;
  int m_wait;

  function automatic int tx_thr(int c);
    case (c) 0: return 0; 1: return WD / 4; 2: return WD / 2; default: return 3 * WD / 4; endcase
  endfunction
  function automatic int rx_thr(int c);
    case (c) 0: return RD / 8; 1: return RD / 4; 2: return RD / 2;
      3: return 3 * RD / 4; 4: return 7 * RD / 8; default: return RD; endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tx = 0; m_rx = 0; m_abort = 0; m_err = 0; m_mask = 0; m_wait = 0;
    end else begin
      bit t;
      t = hold_off && (max_wait != 0) && (m_wait == int'(max_wait));
      if (!hold_off || max_wait == 0 || t) m_wait = 0; else m_wait = m_wait + 1;
      m_abort = t;
      m_tx = int'(wr_count) <= tx_thr(int'(tx_lvl));
      m_rx = int'(rd_count) >= rx_thr(int'(rx_lvl));
      if (err_clr_we) m_err = m_err & ~err_clr_bits;
      if (wfull_ev && wfull_err_en) m_err[0] = 1;
      if (rstall_ev && rstall_err_en) m_err[1] = 1;
      if (t) m_err[2] = 1;
      if (mask_we) m_mask = mask_wdata;
    end
  end

  task automatic chk(input logic got, input bit exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s (phase %s): got %0b expected %0b at %0t", req, what, phase, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit [2:0] raw;
    raw = {|m_err, m_rx, m_tx};
    chk(raw_status[0], m_tx, "R1", "tx request");
    chk(raw_status[1], m_rx, "R2", "rx request");
    chk(err_flags[0], m_err[0], "R3", "write-full flag");
    chk(err_flags[1], m_err[1], "R4", "read-stall flag");
    chk(err_flags[2], m_err[2], "R5", "timeout flag");
    chk(xfer_abort, m_abort, "R5", "abort pulse");
    chk(raw_status[2], |m_err, "R9", "error status");
    for (int i = 0; i < 3; i++) chk(masked_status[i], raw[i] & m_mask[i], "R10", "masked bit");
    chk(irq, |(raw & m_mask), "R10", "irq");
  endtask

  task automatic idle_inputs();
    wfull_ev = 0; rstall_ev = 0; mask_we = 0; err_clr_we = 0;
  endtask

  task automatic cycle();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wr_count = 5'd8; rd_count = 5'd8;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(irq, 0, "R11", "irq in reset");
    for (int i = 0; i < 3; i++) begin
      chk(raw_status[i], 0, "R11", "raw in reset");
      chk(err_flags[i], 0, "R11", "flag in reset");
    end
    chk(xfer_abort, 0, "R11", "abort in reset");
    rst_n = 1;
    cycle();

    // R6: zero max wait never times out
    phase = "R6";
    mask_we = 1; mask_wdata = 3'b111; max_wait = 0; hold_off = 1;
    cycle(); idle_inputs();
    repeat (300) cycle();
    chk(err_flags[2], 0, "R6", "no timeout with zero max wait");

    // R5: timeout after N+1 held cycles
    phase = "R5";
    hold_off = 0; cycle();
    max_wait = 5; hold_off = 1;
    repeat (20) cycle();
    hold_off = 0; cycle();
    chk(err_flags[2], 1, "R5", "timeout flag after long stall");

    // R3/R4: enables gate the events
    phase = "R3";
    wfull_ev = 1; rstall_ev = 1; cycle(); idle_inputs(); cycle();
    chk(err_flags[0], 0, "R3", "disabled write-full ignored");
    chk(err_flags[1], 0, "R4", "disabled read-stall ignored");
    wfull_err_en = 1; rstall_err_en = 1;
    wfull_ev = 1; rstall_ev = 1; cycle(); idle_inputs(); cycle();

    // R7: write-one-to-clear
    phase = "R7";
    err_clr_we = 1; err_clr_bits = 3'b101; cycle(); idle_inputs(); cycle();
    chk(err_flags[1], 1, "R7", "zero bit keeps flag");
    err_clr_we = 1; err_clr_bits = 3'b111; cycle(); idle_inputs(); cycle();

    // R8: event wins over same-cycle clear
    phase = "R8";
    wfull_ev = 1; err_clr_we = 1; err_clr_bits = 3'b111; cycle(); idle_inputs();
    chk(err_flags[0], 1, "R8", "set beats clear");
    cycle();

    // R1/R2: level sweeps
    phase = "R1";
    for (int l = 0; l < 4; l++)
      for (int c = 0; c <= WD; c++) begin
        tx_lvl = 2'(l); wr_count = WCW'(c); cycle();
      end
    phase = "R2";
    for (int l = 0; l < 8; l++)
      for (int c = 0; c <= RD; c++) begin
        rx_lvl = 3'(l); rd_count = RCW'(c); cycle();
      end

    // mixed traffic
    phase = "R10";
    for (int n = 0; n < 4000; n++) begin
      wr_count = WCW'($urandom_range(0, WD));
      rd_count = RCW'($urandom_range(0, RD));
      if ($urandom_range(0, 15) == 0) tx_lvl = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 15) == 0) rx_lvl = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 63) == 0) max_wait = MWW'($urandom_range(0, 6));
      if ($urandom_range(0, 31) == 0) begin
        wfull_err_en = 1'($urandom_range(0, 1)); rstall_err_en = 1'($urandom_range(0, 1));
      end
      hold_off = ($urandom_range(0, 7) != 0);
      wfull_ev = ($urandom_range(0, 19) == 0);
      rstall_ev = ($urandom_range(0, 19) == 0);
      mask_we = ($urandom_range(0, 9) == 0); mask_wdata = 3'($urandom_range(0, 7));
      err_clr_we = ($urandom_range(0, 5) == 0); err_clr_bits = 3'($urandom_range(0, 7));
      cycle();
    end
    idle_inputs(); cycle();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule